// File: doc/BRIEF.md
# Rotating-Priority Interrupt Request Resolver

This block is the core of an eight-line interrupt controller. Each request line is captured as either edge- or level-triggered, depending on a per-line mode bit. Captured requests are held in a pending register, and unmasked pending lines compete for service. Priority is measured from a programmable rotation base: the line at the base is the highest priority, and priority falls as the index rises, wrapping modulo eight.

The resolver keeps an in-service register. It raises its interrupt output only when the best pending candidate strictly outranks the best line already in service. On a master unit, a nesting-mode control can remove the cascade line from that in-service comparison, so a second request on the cascade line can get through.

Acknowledge and clear strobes each carry a line index. The acknowledge strobe moves a line into service. In auto-clear mode the in-service bit is not kept, and the base can optionally rotate past the acknowledged line. Command decoding, cascading between units and vector formation belong to the surrounding logic.

Top module: `prio_irq_core`

## Requirements
- R1: A synchronous reset, active high, clears the pending, level-history, mask, in-service and rotation-base registers. After the reset edge, `win_valid` and `irq_out` are 0.
- R2: A line whose `trig_lvl` bit is 0 is edge-triggered. Its pending bit is set only when the line was low at the previous edge and is high at this edge. A low level, or a level held high, never clears the pending bit.
- R3: A line whose `trig_lvl` bit is 1 is level-triggered. At each edge its pending bit takes the value of the line.
- R4: Each candidate has a relative priority of (index − base) mod 8, and 0 is the best. `win_idx` is the unmasked pending line with the smallest relative priority.
- R5: A mask bit of 1 removes that line from the candidates. Its pending bit is still captured.
- R6: `win_valid` is 1 only when the best candidate's relative priority is strictly smaller than the best relative priority among the in-service bits. An empty set ranks 8.
- R7: When the unit is a master and `nest_excl` is 1, in-service bit 2 is left out of the R6 comparison.
- R8: With `auto_eoi` at 0, `ack` sets the in-service bit at `ack_idx`. For an edge-triggered line, `ack` also clears that line's pending bit, even if a new rising edge arrives in the same cycle. For a level-triggered line, `ack` leaves the pending bit alone.
- R9: With `auto_eoi` at 1, `ack` leaves the in-service bit at `ack_idx` at 0. If `rot_aeoi` is also 1, the base becomes (`ack_idx` + 1) mod 8, and this takes precedence over a `rot_we` load in the same cycle.
- R10: `clr` clears the in-service bit at `clr_idx`. When `ack` and `clr` name the same line in one cycle, the `ack` result wins.
- R11: The effects of line levels, strobes, mask loads and base loads appear on the outputs only after the next rising edge. `irq_out` always equals `win_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_in | input | 8 | Interrupt request lines |
| trig_lvl | input | 8 | Per-line trigger mode: 1 level, 0 edge |
| mask_we | input | 1 | Load strobe for the mask register |
| mask_val | input | 8 | New mask value (1 masks the line) |
| rot_we | input | 1 | Load strobe for the rotation base |
| rot_val | input | 3 | New rotation base |
| nest_excl | input | 1 | Leave cascade line 2 out of the in-service rank (master only) |
| auto_eoi | input | 1 | Auto-clear of the in-service bit on acknowledge |
| rot_aeoi | input | 1 | Rotate the base past the line acknowledged under auto-clear |
| ack | input | 1 | Acknowledge strobe |
| ack_idx | input | 3 | Line being acknowledged |
| clr | input | 1 | In-service clear strobe |
| clr_idx | input | 3 | Line whose in-service bit is cleared |
| win_idx | output | 3 | Index of the winning line |
| win_valid | output | 1 | A winner outranks everything in service |
| irq_out | output | 1 | Interrupt request output |

## Verification
The checker tests a set of properties on every cycle. A reported winner must be pending, unmasked and not itself in service, unless nesting exclusion applies. Level lines must track their input. Acknowledge must have its effect on in-service state, pending state and the rotation base.

Only the bench scenarios can show the rest. These are the exact winner chosen across all bases and request patterns, the strict-outrank rule against each in-service line, and the fact that a held-high edge line does not re-arm. Interleavings of masks, acknowledges, clears and mode changes are also covered only by the bench.

// File: rtl/prio_irq_pkg.sv
`timescale 1ns/1ps
package prio_irq_pkg;
  localparam int unsigned DEF_LINES   = 8;
  localparam int unsigned DEF_CASCADE = 2;

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;
endpackage

// File: rtl/prio_irq_capture.sv
`timescale 1ns/1ps
module prio_irq_capture #(
  parameter int unsigned N  = prio_irq_pkg::DEF_LINES,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req_in,
  input  logic [N-1:0]  trig_lvl,
  input  logic          ack,
  input  logic [IW-1:0] ack_idx,
  output logic [N-1:0]  pend_q,
  output logic [N-1:0]  hist_q
);
  import prio_irq_pkg::*;

  for (genvar g = 0; g < N; g++) begin : g_line
    logic is_level;
    logic rise_evt;
    logic ack_hit;

    assign is_level = (trig_e'(trig_lvl[g]) == TRIG_LEVEL);
    assign rise_evt = req_in[g] & ~hist_q[g];
    assign ack_hit  = ack && (ack_idx == IW'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        pend_q[g] <= 1'b0;
        hist_q[g] <= 1'b0;
      end else begin
        hist_q[g] <= req_in[g];
        if (is_level)
          pend_q[g] <= req_in[g];
        else if (ack_hit)
          pend_q[g] <= 1'b0;
        else if (rise_evt)
          pend_q[g] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/prio_irq_service.sv
`timescale 1ns/1ps
module prio_irq_service #(
  parameter int unsigned N  = prio_irq_pkg::DEF_LINES,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mask_we,
  input  logic [N-1:0]  mask_val,
  input  logic          rot_we,
  input  logic [IW-1:0] rot_val,
  input  logic          auto_eoi,
  input  logic          rot_aeoi,
  input  logic          ack,
  input  logic [IW-1:0] ack_idx,
  input  logic          clr,
  input  logic [IW-1:0] clr_idx,
  output logic [N-1:0]  mask_q,
  output logic [N-1:0]  insvc_q,
  output logic [IW-1:0] rot_q,
  output logic          aeoi_rot_evt
);
  logic [N-1:0] insvc_d;

  assign aeoi_rot_evt = ack && auto_eoi && rot_aeoi;

  always_comb begin
    insvc_d = insvc_q;
    if (clr) insvc_d[clr_idx] = 1'b0;
    if (ack) insvc_d[ack_idx] = ~auto_eoi;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      insvc_q <= '0;
      rot_q   <= '0;
    end else begin
      insvc_q <= insvc_d;
      if (mask_we) mask_q <= mask_val;
      if (aeoi_rot_evt)
        rot_q <= ack_idx + IW'(1);
      else if (rot_we)
        rot_q <= rot_val;
    end
  end
endmodule

// File: rtl/prio_irq_resolve.sv
`timescale 1ns/1ps
module prio_irq_resolve #(
  parameter int unsigned N         = prio_irq_pkg::DEF_LINES,
  parameter int unsigned IW        = $clog2(N),
  parameter int unsigned PW        = IW + 1,
  parameter bit          IS_MASTER = 1'b1,
  parameter int unsigned CASCADE   = prio_irq_pkg::DEF_CASCADE
) (
  input  logic [N-1:0]  pend_q,
  input  logic [N-1:0]  mask_q,
  input  logic [N-1:0]  insvc_q,
  input  logic [IW-1:0] rot_q,
  input  logic          nest_excl,
  output logic [PW-1:0] cand_prio,
  output logic [PW-1:0] insvc_prio,
  output logic [IW-1:0] win_idx,
  output logic          win_valid
);
  logic [N-1:0] cand_vec;
  logic [N-1:0] rank_vec;

  function automatic logic [PW-1:0] scan_rank(input logic [N-1:0] v,
                                               input logic [IW-1:0] base);
    logic [PW-1:0] r;
    r = PW'(N);
    for (int k = N - 1; k >= 0; k--) begin
      if (v[IW'(k) + base]) r = PW'(k);
    end
    return r;
  endfunction

  assign cand_vec = pend_q & ~mask_q;

  if (IS_MASTER) begin : g_master
    always_comb begin
      rank_vec = insvc_q;
      if (nest_excl) rank_vec[CASCADE] = 1'b0;
    end
  end else begin : g_slave
    assign rank_vec = insvc_q;
  end

  assign cand_prio  = scan_rank(cand_vec, rot_q);
  assign insvc_prio = scan_rank(rank_vec, rot_q);
  assign win_valid  = cand_prio < insvc_prio;
  assign win_idx    = cand_prio[IW-1:0] + rot_q;
endmodule

// File: rtl/prio_irq_core.sv
`timescale 1ns/1ps
module prio_irq_core #(
  parameter int unsigned N_LINES   = prio_irq_pkg::DEF_LINES,
  parameter bit          IS_MASTER = 1'b1,
  parameter int unsigned CASCADE   = prio_irq_pkg::DEF_CASCADE,
  localparam int unsigned IDX_W    = $clog2(N_LINES),
  localparam int unsigned PRIO_W   = IDX_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] req_in,
  input  logic [N_LINES-1:0] trig_lvl,
  input  logic               mask_we,
  input  logic [N_LINES-1:0] mask_val,
  input  logic               rot_we,
  input  logic [IDX_W-1:0]   rot_val,
  input  logic               nest_excl,
  input  logic               auto_eoi,
  input  logic               rot_aeoi,
  input  logic               ack,
  input  logic [IDX_W-1:0]   ack_idx,
  input  logic               clr,
  input  logic [IDX_W-1:0]   clr_idx,
  output logic [IDX_W-1:0]   win_idx,
  output logic               win_valid,
  output logic               irq_out
);
  logic [N_LINES-1:0] pend_q;
  logic [N_LINES-1:0] hist_q;
  logic [N_LINES-1:0] mask_q;
  logic [N_LINES-1:0] insvc_q;
  logic [IDX_W-1:0]   rot_q;
  logic               aeoi_rot_evt;
  logic [PRIO_W-1:0]  cand_prio;
  logic [PRIO_W-1:0]  insvc_prio;

  prio_irq_capture #(.N(N_LINES), .IW(IDX_W)) u_capture (
    .clk     (clk),
    .rst     (rst),
    .req_in  (req_in),
    .trig_lvl(trig_lvl),
    .ack     (ack),
    .ack_idx (ack_idx),
    .pend_q  (pend_q),
    .hist_q  (hist_q)
  );

  prio_irq_service #(.N(N_LINES), .IW(IDX_W)) u_service (
    .clk         (clk),
    .rst         (rst),
    .mask_we     (mask_we),
    .mask_val    (mask_val),
    .rot_we      (rot_we),
    .rot_val     (rot_val),
    .auto_eoi    (auto_eoi),
    .rot_aeoi    (rot_aeoi),
    .ack         (ack),
    .ack_idx     (ack_idx),
    .clr         (clr),
    .clr_idx     (clr_idx),
    .mask_q      (mask_q),
    .insvc_q     (insvc_q),
    .rot_q       (rot_q),
    .aeoi_rot_evt(aeoi_rot_evt)
  );

  prio_irq_resolve #(
    .N(N_LINES), .IW(IDX_W), .PW(PRIO_W),
    .IS_MASTER(IS_MASTER), .CASCADE(CASCADE)
  ) u_resolve (
    .pend_q    (pend_q),
    .mask_q    (mask_q),
    .insvc_q   (insvc_q),
    .rot_q     (rot_q),
    .nest_excl (nest_excl),
    .cand_prio (cand_prio),
    .insvc_prio(insvc_prio),
    .win_idx   (win_idx),
    .win_valid (win_valid)
  );

  assign irq_out = win_valid;
endmodule

// File: rtl/prio_irq_core_chk.sv
`timescale 1ns/1ps
module prio_irq_core_chk #(
  parameter int unsigned N         = 8,
  parameter int unsigned IW        = 3,
  parameter bit          IS_MASTER = 1'b1,
  parameter int unsigned CASCADE   = 2
) (
  input logic          clk,
  input logic          rst,
  input logic [N-1:0]  req_in,
  input logic [N-1:0]  trig_lvl,
  input logic          nest_excl,
  input logic          auto_eoi,
  input logic          rot_aeoi,
  input logic          ack,
  input logic [IW-1:0] ack_idx,
  input logic [N-1:0]  pend_q,
  input logic [N-1:0]  mask_q,
  input logic [N-1:0]  insvc_q,
  input logic [IW-1:0] rot_q,
  input logic          aeoi_rot_evt,
  input logic [IW-1:0] win_idx,
  input logic          win_valid,
  input logic          irq_out
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!irq_out && insvc_q == '0 && rot_q == '0 && pend_q == '0));

  p_win_pending_r4: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> pend_q[win_idx]);

  p_win_unmasked_r5: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> !mask_q[win_idx]);

  p_win_not_inserv_r6: assert property (@(posedge clk) disable iff (rst)
    (win_valid && !(IS_MASTER && nest_excl && win_idx == IW'(CASCADE)))
      |-> !insvc_q[win_idx]);

  p_ack_sets_r8: assert property (@(posedge clk) disable iff (rst)
    (ack && !auto_eoi) |=> insvc_q[$past(ack_idx)]);

  p_edge_ack_drops_r8: assert property (@(posedge clk) disable iff (rst)
    (ack && !trig_lvl[ack_idx]) |=> !pend_q[$past(ack_idx)]);

  p_aeoi_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (ack && auto_eoi) |=> !insvc_q[$past(ack_idx)]);

  p_aeoi_rotate_r9: assert property (@(posedge clk) disable iff (rst)
    aeoi_rot_evt |=> (rot_q == IW'($past(ack_idx) + IW'(1))));

  p_irq_follows_r11: assert property (@(posedge clk) disable iff (rst)
    ack |=> (irq_out == win_valid));

  for (genvar i = 0; i < N; i++) begin : g_lvl
    p_level_follow_r3: assert property (@(posedge clk) disable iff (rst)
      trig_lvl[i] |=> (pend_q[i] == $past(req_in[i])));
  end
endmodule

bind prio_irq_core prio_irq_core_chk #(
  .N(N_LINES), .IW(IDX_W), .IS_MASTER(IS_MASTER), .CASCADE(CASCADE)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_in      (req_in),
  .trig_lvl    (trig_lvl),
  .nest_excl   (nest_excl),
  .auto_eoi    (auto_eoi),
  .rot_aeoi    (rot_aeoi),
  .ack         (ack),
  .ack_idx     (ack_idx),
  .pend_q      (pend_q),
  .mask_q      (mask_q),
  .insvc_q     (insvc_q),
  .rot_q       (rot_q),
  .aeoi_rot_evt(aeoi_rot_evt),
  .win_idx     (win_idx),
  .win_valid   (win_valid),
  .irq_out     (irq_out)
);

// File: tb/prio_irq_core_tb.sv
`timescale 1ns/1ps
module prio_irq_core_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst = 1'b1;
  logic [7:0] req_in = '0, trig_lvl = '1, mask_val = '0;
  logic       mask_we = 0, rot_we = 0, nest_excl = 0, auto_eoi = 0, rot_aeoi = 0;
  logic       ack = 0, clr = 0;
  logic [2:0] rot_val = '0, ack_idx = '0, clr_idx = '0;
  wire  [2:0] win_idx;
  wire        win_valid, irq_out;

  int vectors = 0;
  int miscompares = 0;

  logic [7:0] m_pend = '0, m_hist = '0, m_insvc = '0, m_mask = '0;
  logic [2:0] m_rot = '0;

  prio_irq_core u_dut (
    .clk(clk), .rst(rst), .req_in(req_in), .trig_lvl(trig_lvl),
    .mask_we(mask_we), .mask_val(mask_val), .rot_we(rot_we), .rot_val(rot_val),
    .nest_excl(nest_excl), .auto_eoi(auto_eoi), .rot_aeoi(rot_aeoi),
    .ack(ack), .ack_idx(ack_idx), .clr(clr), .clr_idx(clr_idx),
    .win_idx(win_idx), .win_valid(win_valid), .irq_out(irq_out)
  );

  // relative rank = distance from base going upward, modulo 8; 8 = empty
  function automatic int rel_rank(logic [7:0] v, logic [2:0] base);
    int best = 8;
    for (int i = 0; i < 8; i++) begin
      if (v[i]) begin
        int d;
        d = (i - int'(base) + 8) % 8;
        if (d < best) best = d;
      end
    end
    return best;
  endfunction

  task automatic model_update();
    if (rst) begin
      m_pend = '0; m_hist = '0; m_insvc = '0; m_mask = '0; m_rot = '0;
    end else begin
      for (int i = 0; i < 8; i++) begin
        if (trig_lvl[i]) m_pend[i] = req_in[i];
        else if (req_in[i] && !m_hist[i]) m_pend[i] = 1'b1;
        m_hist[i] = req_in[i];
      end
      if (ack && !trig_lvl[ack_idx]) m_pend[ack_idx] = 1'b0;
      if (clr) m_insvc[clr_idx] = 1'b0;
      if (ack) m_insvc[ack_idx] = !auto_eoi;
      if (ack && auto_eoi && rot_aeoi) m_rot = ack_idx + 3'd1;
      else if (rot_we) m_rot = rot_val;
      if (mask_we) m_mask = mask_val;
    end
  endtask

  task automatic compare(string tag);
    logic [7:0] ins;
    int pc, pi;
    logic ev;
    logic [2:0] ei;
    ins = m_insvc;
    if (nest_excl) ins[2] = 1'b0;
    pc = rel_rank(m_pend & ~m_mask, m_rot);
    pi = rel_rank(ins, m_rot);
    ev = (pc < pi);
    ei = 3'((pc + int'(m_rot)) % 8);
    vectors++;
    if (win_valid !== ev || irq_out !== ev || (ev && win_idx !== ei)) begin
      miscompares++;
      $display("FAIL %s: valid=%b irq=%b idx=%0d, expected valid=%b idx=%0d",
               tag, win_valid, irq_out, win_idx, ev, ei);
    end
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    model_update();
    #1;
    compare(tag);
    ack = 0; clr = 0; mask_we = 0; rot_we = 0;
  endtask

  task automatic do_reset();
    rst = 1;
    tick("R1");
    tick("R1");
    rst = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #1;
    do_reset();

    // R2: edge-triggered capture, hold-high does not re-arm
    trig_lvl = 8'h00; req_in = 8'h20; tick("R2");
    ack = 1; ack_idx = 3'd5; tick("R8");
    clr = 1; clr_idx = 3'd5; tick("R2");
    req_in = 8'h00; tick("R2");
    req_in = 8'h20; tick("R2");
    req_in = 8'h00; tick("R2");
    ack = 1; ack_idx = 3'd5; req_in = 8'h20; tick("R8");
    clr = 1; clr_idx = 3'd5; req_in = 8'h00; tick("R10");

    // R3: level lines follow the input; ack keeps them pending
    trig_lvl = 8'hFF; req_in = 8'h08; tick("R3");
    req_in = 8'h00; tick("R3");
    req_in = 8'h08; tick("R3");
    ack = 1; ack_idx = 3'd3; tick("R8");
    clr = 1; clr_idx = 3'd3; tick("R3");
    req_in = 8'h00; tick("R3");

    // R11: inputs take effect only after the next edge
    req_in = 8'h10; #1; compare("R11"); tick("R11");
    req_in = 8'h00; #1; compare("R11"); tick("R11");

    // R4: every base against every request pattern
    for (int r = 0; r < 8; r++)
      for (int p = 0; p < 256; p++) begin
        rot_we = 1; rot_val = 3'(r); req_in = 8'(p); tick("R4");
      end

    // R5: every mask against random requests
    for (int m = 0; m < 256; m++) begin
      mask_we = 1; mask_val = 8'(m); rot_we = 1; rot_val = 3'($urandom);
      req_in = 8'($urandom); tick("R5");
    end
    mask_we = 1; mask_val = 8'h00; tick("R5");

    // R6: each in-service line against every request pattern
    for (int j = 0; j < 8; j++) begin
      req_in = 8'h00; rot_we = 1; rot_val = 3'($urandom);
      ack = 1; ack_idx = 3'(j); tick("R8");
      for (int p = 0; p < 256; p++) begin
        req_in = 8'(p); tick("R6");
      end
      clr = 1; clr_idx = 3'(j); tick("R10");
    end

    // R7: cascade line excluded from in-service rank
    rot_we = 1; rot_val = 3'd0; req_in = 8'h00; ack = 1; ack_idx = 3'd2; tick("R7");
    req_in = 8'h04; tick("R7");
    nest_excl = 1; #1; compare("R7");
    req_in = 8'h20; tick("R7");
    nest_excl = 0; #1; compare("R7");
    clr = 1; clr_idx = 3'd2; tick("R7");

    // R9: auto-clear with rotation, and precedence over a base load
    req_in = 8'hFF; auto_eoi = 1; rot_aeoi = 1;
    for (int k = 0; k < 8; k++) begin
      ack = 1; ack_idx = 3'(k); rot_we = 1; rot_val = 3'(k + 4); tick("R9");
    end
    rot_aeoi = 0;
    ack = 1; ack_idx = 3'd6; tick("R9");
    auto_eoi = 0;

    // R10: ack and clear on the same line, ack wins
    rot_we = 1; rot_val = 3'd0; tick("R10");
    ack = 1; ack_idx = 3'd4; clr = 1; clr_idx = 3'd4; tick("R10");
    clr = 1; clr_idx = 3'd4; tick("R10");

    // mixed random traffic
    for (int c = 0; c < 4000; c++) begin
      req_in = 8'($urandom);
      if (($urandom % 16) == 0) trig_lvl = 8'($urandom);
      mask_we = (($urandom % 8) == 0); mask_val = 8'($urandom) & 8'($urandom);
      rot_we = (($urandom % 8) == 0); rot_val = 3'($urandom);
      ack = (($urandom % 4) == 0); ack_idx = 3'($urandom);
      clr = (($urandom % 3) == 0); clr_idx = 3'($urandom);
      auto_eoi = (($urandom % 4) == 0); rot_aeoi = 1'($urandom);
      nest_excl = 1'($urandom);
      tick("R4 mixed");
    end

    do_reset();
    tick("R1");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule